// File: doc/BRIEF.md
# Adaptive Decision Feedback Equalizer

This block equalizes a stream of digitized receive samples, one sample per unit interval. Each accepted sample has inter-symbol interference from earlier symbols removed. The block keeps the most recent hard decisions in a shift register and maps each stored decision to +1 or -1. It multiplies each one by its own signed tap weight and subtracts the total from the incoming sample, all within the same sample period. The sign of the corrected sample is the new decision. Only trailing (post-cursor) interference is cancelled. No tap looks at the current symbol or at later ones, so leading interference passes through unchanged.

The tap weights come from one of four sources, chosen by a mode input. They can be copied from a set of manual values. They can be trained by a calibration run that stops after a programmed number of symbols. They can track the channel without stopping. Or they can be frozen at their current values. Training uses a sign-sign least-mean-squares rule. After each decision, every weight moves by a programmable step toward the value that lowers the error. The error is the corrected sample minus the ideal level for the decision taken. Every trained weight is clamped between programmable signed limits. The number of taps is a parameter, and 11 and 15 are the intended settings.

Top module: `dfe_adapt`

## Requirements
- R1: When `in_valid` is high at a rising edge, at that edge `out_valid` rises and `eq_out` takes y = in_sample - sum over taps i of w_i * f_i. Here f_i is +1 if the stored decision i is 1 and -1 if it is 0. When `in_valid` is low, `out_valid` is low after the edge.
- R2: `dec_out` is 1 exactly when y >= 0. It is registered with `eq_out`, and a stored decision of 1 counts as +1 in the feedback and 0 counts as -1.
- R3: Reset clears the outputs and the weights to 0 and fills the decision history with 0 (all -1). Each accepted sample shifts its decision into history slot 1, and slot i holds the decision made i accepted samples earlier.
- R4: In manual mode (mode code 0), the weights equal `manual_w` as sampled at the previous edge. Tap i (1-based) occupies bits [(i-1)*WEIGHT_W +: WEIGHT_W] of both `manual_w` and `weights_out`.
- R5: In tracking mode (code 2), every accepted sample changes each weight w_i by step * sign(e) * f_i, where e = y - (dec ? ideal_level : -ideal_level).
- R6: When e is exactly zero, no weight changes.
- R7: An update that would move a weight above `w_max` or below `w_min` leaves the weight at that limit. The result never wraps.
- R8: In calibration mode (code 1), the rule of R5 applies to the first `cal_len` accepted samples only. After that the weights hold, and `cal_done` rises at the edge that applies the last update.
- R9: Whenever the mode is not calibration, the calibration count and `cal_done` clear at the next edge. Entering calibration again starts a new run, and with `cal_len` = 0 `cal_done` rises one edge after entry with no update.
- R10: In hold mode (code 3), the weights do not change, while equalization and decisions continue.
- R11: A cycle with `in_valid` low changes neither the weights nor the history, and `eq_out` and `dec_out` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle at most |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed receive sample |
| mode | input | 2 | 0 manual, 1 calibration, 2 tracking, 3 hold |
| manual_w | input | NUM_TAPS*WEIGHT_W | Signed manual weights, tap 1 lowest |
| step | input | STEP_W | Unsigned adaptation step |
| ideal_level | input | SAMPLE_W | Unsigned ideal symbol magnitude |
| w_min | input | WEIGHT_W | Signed lower weight limit |
| w_max | input | WEIGHT_W | Signed upper weight limit |
| cal_len | input | CNT_W | Number of calibration updates |
| out_valid | output | 1 | Result strobe |
| dec_out | output | 1 | Hard decision, 1 means +1 |
| eq_out | output | ACC_W | Signed equalized sample |
| weights_out | output | NUM_TAPS*WEIGHT_W | Current signed weights, tap 1 lowest |
| cal_done | output | 1 | Calibration run finished |

## Verification
Every result of an accepted sample lands at the first rising edge after the sample is presented. This covers the equalized value, the decision, the strobe, the weight update, the calibration count and the done flag. The feedback sum uses the weights and history registered before that edge, so the new weights first affect the next sample. The bench drives inputs on the falling edge and compares every output at the following falling edge. It keeps a cycle-exact arithmetic model that updates its own weights and history at the same point.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_CAL    = 2'd1,
        MODE_TRACK  = 2'd2,
        MODE_HOLD   = 2'd3
    } dfe_mode_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dfe_history.sv
module dfe_history #(
    parameter int NUM_TAPS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                new_dec,
    output logic [NUM_TAPS-1:0] hist
);
    logic [NUM_TAPS-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[NUM_TAPS-2:0], new_dec};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;
endmodule

// File: rtl/dfe_fb_sum.sv
module dfe_fb_sum #(
    parameter int NUM_TAPS = 11,
    parameter int WEIGHT_W = 8,
    parameter int SUM_W    = 12
) (
    input  logic [NUM_TAPS*WEIGHT_W-1:0] weights,
    input  logic [NUM_TAPS-1:0]          hist,
    output logic signed [SUM_W-1:0]      sum
);
    logic signed [SUM_W-1:0] term [NUM_TAPS];
    logic signed [SUM_W-1:0] part [NUM_TAPS+1];

    assign part[0] = '0;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        logic signed [SUM_W-1:0] w_ext;
        assign w_ext = {{(SUM_W-WEIGHT_W){weights[i*WEIGHT_W+WEIGHT_W-1]}},
                        weights[i*WEIGHT_W +: WEIGHT_W]};
        // a stored 1 is +1 and a stored 0 is -1: sign flip, no multiplier
        assign term[i]   = hist[i] ? w_ext : -w_ext;
        assign part[i+1] = part[i] + term[i];
    end

    assign sum = part[NUM_TAPS];
endmodule

// File: rtl/dfe_tap_update.sv
module dfe_tap_update #(
    parameter int WEIGHT_W = 8,
    parameter int STEP_W   = 4
) (
    input  logic [WEIGHT_W-1:0] w_cur,
    input  logic                past_dec,
    input  logic                err_pos,
    input  logic                err_neg,
    input  logic [STEP_W-1:0]   step,
    input  logic [WEIGHT_W-1:0] w_min,
    input  logic [WEIGHT_W-1:0] w_max,
    output logic [WEIGHT_W-1:0] w_next
);
    localparam int XW = dfe_pkg::max_of(WEIGHT_W, STEP_W) + 2;

    logic signed [XW-1:0] cur_x, step_x, min_x, max_x, raw;
    logic                 go_up, go_down;

    always_comb begin
        cur_x   = {{(XW-WEIGHT_W){w_cur[WEIGHT_W-1]}}, w_cur};
        min_x   = {{(XW-WEIGHT_W){w_min[WEIGHT_W-1]}}, w_min};
        max_x   = {{(XW-WEIGHT_W){w_max[WEIGHT_W-1]}}, w_max};
        step_x  = {{(XW-STEP_W){1'b0}}, step};
        go_up   = (err_pos & past_dec) | (err_neg & ~past_dec);
        go_down = (err_pos & ~past_dec) | (err_neg & past_dec);
        raw     = cur_x;
        if (go_up) begin
            raw = cur_x + step_x;
        end else if (go_down) begin
            raw = cur_x - step_x;
        end
        if (go_up || go_down) begin
            if (raw > max_x) raw = max_x;
            if (raw < min_x) raw = min_x;
        end
        w_next = raw[WEIGHT_W-1:0];
    end
endmodule

// File: rtl/dfe_adapt.sv
module dfe_adapt #(
    parameter int NUM_TAPS = 11,
    parameter int SAMPLE_W = 12,
    parameter int WEIGHT_W = 8,
    parameter int STEP_W   = 4,
    parameter int CNT_W    = 16,
    localparam int SUM_W   = WEIGHT_W + $clog2(NUM_TAPS + 1),
    localparam int ACC_W   = dfe_pkg::max_of(SAMPLE_W, SUM_W) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [SAMPLE_W-1:0]          in_sample,
    input  logic [1:0]                   mode,
    input  logic [NUM_TAPS*WEIGHT_W-1:0] manual_w,
    input  logic [STEP_W-1:0]            step,
    input  logic [SAMPLE_W-1:0]          ideal_level,
    input  logic [WEIGHT_W-1:0]          w_min,
    input  logic [WEIGHT_W-1:0]          w_max,
    input  logic [CNT_W-1:0]             cal_len,
    output logic                         out_valid,
    output logic                         dec_out,
    output logic [ACC_W-1:0]             eq_out,
    output logic [NUM_TAPS*WEIGHT_W-1:0] weights_out,
    output logic                         cal_done
);
    import dfe_pkg::*;

    localparam int ERR_W = ACC_W + 1;

    typedef struct packed {
        logic                               out_valid;
        logic                               dec;
        logic [ACC_W-1:0]                   eq;
        logic [NUM_TAPS-1:0][WEIGHT_W-1:0]  w;
        logic [CNT_W-1:0]                   cnt;
        logic                               done;
    } state_t;

    state_t s_d, s_q;

    dfe_mode_e                          mode_e;
    logic [NUM_TAPS-1:0]                hist;
    logic signed [SUM_W-1:0]            fb_sum;
    logic signed [ACC_W-1:0]            y_now;
    logic signed [ERR_W-1:0]            err;
    logic signed [ERR_W-1:0]            target;
    logic                               dec_now, err_pos, err_neg;
    logic                               cal_open, upd_en;
    logic [NUM_TAPS-1:0][WEIGHT_W-1:0]  tap_next;

    assign mode_e = dfe_mode_e'(mode);

    dfe_history #(.NUM_TAPS(NUM_TAPS)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .new_dec  (dec_now),
        .hist     (hist)
    );

    dfe_fb_sum #(.NUM_TAPS(NUM_TAPS), .WEIGHT_W(WEIGHT_W), .SUM_W(SUM_W)) sum_i (
        .weights (s_q.w),
        .hist    (hist),
        .sum     (fb_sum)
    );

    // Slicer and error: same cycle as the sample, so feedback closes in one period
    always_comb begin
        y_now   = {{(ACC_W-SAMPLE_W){in_sample[SAMPLE_W-1]}}, in_sample}
                - {{(ACC_W-SUM_W){fb_sum[SUM_W-1]}}, fb_sum};
        dec_now = ~y_now[ACC_W-1];
        target  = dec_now ? {{(ERR_W-SAMPLE_W){1'b0}}, ideal_level}
                          : -{{(ERR_W-SAMPLE_W){1'b0}}, ideal_level};
        err     = {y_now[ACC_W-1], y_now} - target;
        err_neg = err[ERR_W-1];
        err_pos = ~err[ERR_W-1] & (err != '0);
    end

    assign cal_open = (mode_e == MODE_CAL) && (s_q.cnt < cal_len);
    assign upd_en   = in_valid && ((mode_e == MODE_TRACK) || cal_open);

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_upd
        dfe_tap_update #(.WEIGHT_W(WEIGHT_W), .STEP_W(STEP_W)) upd_i (
            .w_cur    (s_q.w[i]),
            .past_dec (hist[i]),
            .err_pos  (err_pos),
            .err_neg  (err_neg),
            .step     (step),
            .w_min    (w_min),
            .w_max    (w_max),
            .w_next   (tap_next[i])
        );
    end

    always_comb begin
        s_d = s_q;
        s_d.out_valid = in_valid;
        if (in_valid) begin
            s_d.dec = dec_now;
            s_d.eq  = y_now;
        end
        unique case (mode_e)
            MODE_MANUAL: s_d.w = manual_w;
            MODE_CAL,
            MODE_TRACK:  if (upd_en) s_d.w = tap_next;
            default:     s_d.w = s_q.w;
        endcase
        if (mode_e != MODE_CAL) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else begin
            if (upd_en) s_d.cnt = s_q.cnt + 1'b1;
            s_d.done = (s_d.cnt >= cal_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid   = s_q.out_valid;
    assign dec_out     = s_q.dec;
    assign eq_out      = s_q.eq;
    assign weights_out = s_q.w;
    assign cal_done    = s_q.done;
endmodule

// File: rtl/dfe_adapt_checker.sv
module dfe_adapt_checker #(
    parameter int NUM_TAPS = 11,
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 13
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [1:0]                   mode,
    input logic [NUM_TAPS*WEIGHT_W-1:0] manual_w,
    input logic [WEIGHT_W-1:0]          w_min,
    input logic [WEIGHT_W-1:0]          w_max,
    input logic                         out_valid,
    input logic                         dec_out,
    input logic [ACC_W-1:0]             eq_out,
    input logic [NUM_TAPS*WEIGHT_W-1:0] weights_out,
    input logic                         cal_done
);
    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_dec_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dec_out == !eq_out[ACC_W-1]));
    assert_manual_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (weights_out == $past(manual_w)));
    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (weights_out == $past(weights_out)));
    assert_cal_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && cal_done) |=> (weights_out == $past(weights_out)));
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1) |=> !cal_done);
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && mode != 2'd0) |=> (weights_out == $past(weights_out)));

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_lim
        logic signed [WEIGHT_W-1:0] wt;
        assign wt = $signed(weights_out[i*WEIGHT_W +: WEIGHT_W]);
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 2'd2 && in_valid && wt >= $signed(w_min) && wt <= $signed(w_max))
            |=> (wt >= $signed($past(w_min)) && wt <= $signed($past(w_max))));
    end
endmodule

bind dfe_adapt dfe_adapt_checker #(
    .NUM_TAPS (NUM_TAPS),
    .WEIGHT_W (WEIGHT_W),
    .ACC_W    (ACC_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .mode        (mode),
    .manual_w    (manual_w),
    .w_min       (w_min),
    .w_max       (w_max),
    .out_valid   (out_valid),
    .dec_out     (dec_out),
    .eq_out      (eq_out),
    .weights_out (weights_out),
    .cal_done    (cal_done)
);

// File: tb/dfe_adapt_tb_top.sv
`timescale 1ns/1ps
module dfe_adapt_tb_top;
    localparam int K   = 11;
    localparam int SW  = 12;
    localparam int W   = 8;
    localparam int STW = 4;
    localparam int CW  = 16;
    localparam int ACC = ((SW > W + $clog2(K + 1)) ? SW : W + $clog2(K + 1)) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [SW-1:0]     in_sample = '0;
    logic [1:0]        mode = 2'd0;
    logic [K*W-1:0]    manual_w = '0;
    logic [STW-1:0]    step = '0;
    logic [SW-1:0]     ideal_level = '0;
    logic [W-1:0]      w_min = '0;
    logic [W-1:0]      w_max = '0;
    logic [CW-1:0]     cal_len = '0;
    logic              out_valid, dec_out, cal_done;
    logic [ACC-1:0]    eq_out;
    logic [K*W-1:0]    weights_out;

    int total = 0;
    int fails = 0;

    int mw [K];
    bit mh [K];
    int mcnt = 0;
    bit mdone = 0;
    int e_eq = 0;
    bit e_dec = 0;
    bit [15:0] lfsr = 16'hACE1;
    bit sym [4];

    always #4 clk = ~clk;

    dfe_adapt #(.NUM_TAPS(K), .SAMPLE_W(SW), .WEIGHT_W(W), .STEP_W(STW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .mode(mode), .manual_w(manual_w), .step(step), .ideal_level(ideal_level),
        .w_min(w_min), .w_max(w_max), .cal_len(cal_len), .out_valid(out_valid),
        .dec_out(dec_out), .eq_out(eq_out), .weights_out(weights_out), .cal_done(cal_done)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr);
    endfunction

    function automatic int dut_w(input int i);
        return int'($signed(weights_out[i*W +: W]));
    endfunction

    task automatic set_manual(input int base, input int mul);
        for (int i = 0; i < K; i++) begin
            int v;
            v = ((i * mul + base) % 101) - 50;
            manual_w[i*W +: W] = W'(v);
        end
    endtask

    // One sample period: drive, model, wait one edge, compare at falling edge
    task automatic do_cycle(input bit v, input int s, input string etag, input string wtag);
        int sum, y, e, sg, tgt, m, lo, hi, idl, clen;
        bit d, upd;
        int nw [K];
        int ncnt;
        bit ndone;
        m = int'(mode);
        lo = int'($signed(w_min));
        hi = int'($signed(w_max));
        idl = int'(ideal_level);
        clen = int'(cal_len);
        sum = 0;
        for (int i = 0; i < K; i++) sum += mh[i] ? mw[i] : -mw[i];
        y = s - sum;
        d = (y >= 0);
        tgt = d ? idl : -idl;
        e = y - tgt;
        sg = (e > 0) ? 1 : ((e < 0) ? -1 : 0);
        upd = v && (m == 2 || (m == 1 && mcnt < clen));
        for (int i = 0; i < K; i++) begin
            nw[i] = mw[i];
            if (m == 0) begin
                nw[i] = int'($signed(manual_w[i*W +: W]));
            end else if (upd && sg != 0) begin
                int t;
                t = mw[i] + sg * (mh[i] ? 1 : -1) * int'(step);
                if (t > hi) t = hi;
                if (t < lo) t = lo;
                nw[i] = t;
            end
        end
        ncnt = (m != 1) ? 0 : mcnt + (upd ? 1 : 0);
        ndone = (m == 1) && (ncnt >= clen);
        if (v) begin
            e_eq = y;
            e_dec = d;
        end
        in_valid = v;
        in_sample = s[SW-1:0];
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == v, v ? "R1" : "R11", "out_valid", int'(out_valid), int'(v));
        chk(int'($signed(eq_out)) == e_eq, v ? etag : "R11", "eq_out", int'($signed(eq_out)), e_eq);
        chk(dec_out == e_dec, v ? "R2" : "R11", "dec_out", int'(dec_out), int'(e_dec));
        for (int i = 0; i < K; i++)
            chk(dut_w(i) == nw[i], wtag, $sformatf("weight tap %0d", i + 1), dut_w(i), nw[i]);
        chk(cal_done == ndone, wtag, "cal_done", int'(cal_done), int'(ndone));
        for (int i = 0; i < K; i++) mw[i] = nw[i];
        mcnt = ncnt;
        mdone = ndone;
        if (v) begin
            for (int i = K - 1; i > 0; i--) mh[i] = mh[i-1];
            mh[0] = d;
        end
    endtask

    // Channel with trailing interference plus small noise
    function automatic int chan_sample();
        int s;
        for (int i = 3; i > 0; i--) sym[i] = sym[i-1];
        sym[0] = rnd() & 1;
        s = (sym[0] ? 64 : -64) + (sym[1] ? 20 : -20) - (sym[2] ? 10 : -10)
            + (sym[3] ? 6 : -6) + (rnd() % 7) - 3;
        return s;
    endfunction

    function automatic int rnd_sample();
        return (rnd() % 401) - 200;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < K; i++) begin mw[i] = 0; mh[i] = 0; end
        for (int i = 0; i < 4; i++) sym[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R3", "reset out_valid", int'(out_valid), 0);
        chk(eq_out == '0, "R3", "reset eq_out", int'($signed(eq_out)), 0);
        chk(weights_out == '0, "R3", "reset weights", int'(weights_out[W-1:0]), 0);
        chk(cal_done == 0, "R3", "reset cal_done", int'(cal_done), 0);
        rst_n = 1'b1;

        // Manual weights; first sample sees an all -1 history
        mode = 2'd0;
        set_manual(7, 37);
        do_cycle(0, 0, "R11", "R4");
        do_cycle(1, 100, "R3", "R4");
        for (int n = 0; n < 80; n++) begin
            if (n == 40) set_manual(3, 53);
            do_cycle((n % 4) != 3, rnd_sample(), "R1", "R4");
        end

        // Continuous tracking on a channel with trailing interference
        ideal_level = SW'(64);
        step = STW'(1);
        w_min = W'(-100);
        w_max = W'(100);
        mode = 2'd2;
        for (int n = 0; n < 400; n++)
            do_cycle((n % 7) != 6, chan_sample(), "R1", "R5");

        // Zero error leaves weights unchanged
        mode = 2'd0;
        manual_w = '0;
        do_cycle(0, 0, "R11", "R4");
        mode = 2'd2;
        do_cycle(1, 64, "R1", "R6");
        do_cycle(1, -64, "R1", "R6");

        // Saturation at tight limits with a large step
        w_min = W'(-5);
        w_max = W'(5);
        step = STW'(3);
        for (int n = 0; n < 60; n++) do_cycle(1, rnd_sample(), "R1", "R7");
        for (int i = 0; i < K; i++)
            chk(dut_w(i) >= -5 && dut_w(i) <= 5, "R7", "weight within limits", dut_w(i), 5);

        // Hold mode: equalize, no training
        mode = 2'd3;
        for (int n = 0; n < 20; n++) do_cycle(1, rnd_sample(), "R1", "R10");

        // One-time calibration
        w_min = W'(-100);
        w_max = W'(100);
        step = STW'(1);
        cal_len = CW'(20);
        mode = 2'd1;
        for (int n = 0; n < 40; n++) do_cycle((n % 5) != 4, chan_sample(), "R1", "R8");
        chk(cal_done == 1, "R8", "cal_done after run", int'(cal_done), 1);

        // Leave, then restart calibration; also a zero-length run
        mode = 2'd2;
        do_cycle(1, chan_sample(), "R1", "R9");
        chk(cal_done == 0, "R9", "cal_done cleared", int'(cal_done), 0);
        mode = 2'd1;
        for (int n = 0; n < 5; n++) do_cycle(1, chan_sample(), "R1", "R9");
        chk(cal_done == 0, "R9", "cal_done during new run", int'(cal_done), 0);
        mode = 2'd3;
        do_cycle(0, 0, "R11", "R9");
        cal_len = '0;
        mode = 2'd1;
        do_cycle(1, chan_sample(), "R1", "R9");
        chk(cal_done == 1, "R9", "cal_done zero length", int'(cal_done), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule